// File: doc/BRIEF.md
# On-Chip Region Access Permission Checker

This block sits in front of the top of a 32-bit flat address map, where the on-chip memories and the control register windows live. Each request carries an address, the identity of the requesting master and the core privilege mode. The block works out which on-chip region the address falls in and decides whether that master may touch it. It returns a region code, a grant and an error flag, all registered, one cycle after the request strobe.

Permission depends on three things together: who is asking, the privilege mode, and a single visibility bit. That bit decides whether the system control registers can be seen from outside the core. A region that a non-core master may not see is reported as reserved space, so no fault names the hidden region. The visibility bit resets to the hidden setting. Only a supervisor-mode core write can change it.

Top module: `mem_region_guard`

## Requirements
- R1: The address is decoded to a region code as follows. 0xFF80_0000–0xFF80_3FFF is code 1, the first data SRAM. 0xFF90_0000–0xFF90_3FFF is code 2, the second data SRAM. 0xFFA0_0000–0xFFA0_3FFF is code 3, the instruction SRAM. 0xFFB0_0000–0xFFB0_0FFF is code 4, the scratchpad. 0xFFC0_0000–0xFFDF_FFFF is code 5, the system control registers. 0xFFE0_0000–0xFFFF_FFFF is code 6, the core control registers. Every other address is code 0, reserved.
- R2: The response appears in the cycle after `req_valid` is sampled high. In a cycle that follows no strobe, `rsp_grant` and `rsp_err` are 0 and `rsp_region` is 0. After reset, all three outputs are 0.
- R3: A request to a reserved address gives `rsp_grant`=0 and `rsp_err`=1.
- R4: Master codes are 0 = core, 1 = DMA, 2 and 3 = external bus masters. `req_priv`=1 means supervisor. A core-register access is granted only to master 0 with `req_priv`=1. A user-mode core access is denied and reports region 6.
- R5: To any master other than 0, the core registers appear as reserved: region 0 is reported and the access is denied.
- R6: A system-register access from the core is granted in supervisor mode and denied in user mode. Both cases report region 5.
- R7: A system-register access from a non-core master is granted with region 5 when the visibility bit is 1. When the bit is 0, it is denied and reports region 0. The privilege input plays no part in this case.
- R8: The visibility bit is 0 after reset. A `cfg_we` pulse loads it from `cfg_vis_wdata` only if, in that same cycle, `req_master`=0 and `req_priv`=1. Any other write attempt leaves it unchanged.
- R9: A scratchpad access from master 1 (DMA) is denied and reports region 4. Masters 0, 2 and 3 are granted in either privilege mode.
- R10: The three SRAM regions (codes 1 to 3) grant every master in either privilege mode.
- R11: Each strobe produces exactly one response cycle in which exactly one of `rsp_grant` and `rsp_err` is 1. The error lasts only that one cycle unless another denied strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_master | input | 2 | Requesting master: 0 core, 1 DMA, 2/3 external |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| cfg_we | input | 1 | Write strobe for the visibility bit |
| cfg_vis_wdata | input | 1 | New visibility value (1 = system registers visible) |
| rsp_region | output | 3 | Registered region code as seen by the master |
| rsp_grant | output | 1 | Registered grant |
| rsp_err | output | 1 | Registered one-cycle error |

## Verification
Some properties are checked by assertions on every cycle. Region hits never overlap. Grant and error never rise together, and neither rises without a preceding strobe. A reserved decode always yields an error. The core registers are never granted to a non-core master or to user mode, and they always show as reserved to non-core masters. A DMA master never receives a scratchpad grant. The visibility bit never moves without a privileged write. Other behaviour only the bench scenarios can show: the exact boundary addresses of each region, and the full cross of master, privilege and visibility. They also show that the reset value of the visibility bit, and write attempts that are ignored, appear as the sweep's system-register responses.

// File: rtl/mrg_pkg.sv
// Package: shared codes and the region table for the region guard.
// Assumes region windows are naturally aligned powers of two that do not overlap.
package mrg_pkg;

    typedef enum logic [2:0] {
        RGN_RESERVED = 3'd0,
        RGN_DATA_A   = 3'd1,
        RGN_DATA_B   = 3'd2,
        RGN_INSTR    = 3'd3,
        RGN_SCRATCH  = 3'd4,
        RGN_SYSREG   = 3'd5,
        RGN_COREREG  = 3'd6
    } region_e;

    localparam int NUM_REGIONS = 6;

    localparam logic [1:0] MST_CORE = 2'd0;
    localparam logic [1:0] MST_DMA  = 2'd1;

    // Base address of table entry idx (entry idx maps to region code idx+1).
    function automatic logic [31:0] region_base(input int idx);
        case (idx)
            0:       return 32'hFF80_0000;
            1:       return 32'hFF90_0000;
            2:       return 32'hFFA0_0000;
            3:       return 32'hFFB0_0000;
            4:       return 32'hFFC0_0000;
            default: return 32'hFFE0_0000;
        endcase
    endfunction

    // log2 of the window size of table entry idx.
    function automatic int region_lg(input int idx);
        case (idx)
            0, 1, 2: return 14;
            3:       return 12;
            default: return 21;
        endcase
    endfunction

endpackage

// File: rtl/mrg_region_decode.sv
// Module: mrg_region_decode
// Decodes an address into a region code by comparing the bits above each
// window size against that window's base. Purely combinational.
// Assumes the table in mrg_pkg holds non-overlapping aligned windows.
module mrg_region_decode
    import mrg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    logic [NUM_REGIONS-1:0] hit;

    // One comparator per window, sized by that window's log2 size.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        localparam int              LG   = region_lg(g);
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(region_base(g));
        assign hit[g] = (addr[ADDR_W-1:LG] == BASE[ADDR_W-1:LG]);
    end

    // Turn the hit vector into a region code; no hit means reserved.
    always_comb begin
        region = RGN_RESERVED;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) region = region_e'(3'(i + 1));
        end
    end

    // R1: the windows never overlap, so at most one comparator fires.
    always_comb begin
        a_onehot_hits_r1: assert ($onehot0(hit));
    end

endmodule

// File: rtl/mrg_vis_cfg.sv
// Module: mrg_vis_cfg
// Holds the single visibility bit that exposes system registers to
// non-core masters. Resets to hidden; only a supervisor core may write it.
module mrg_vis_cfg
    import mrg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       wdata,
    input  logic [1:0] master,
    input  logic       priv,
    output logic       vis
);

    // Load the bit only on a privileged core write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 vis <= 1'b0;
        else if (we && master == MST_CORE && priv)  vis <= wdata;
    end

endmodule

// File: rtl/mrg_access_policy.sv
// Module: mrg_access_policy
// Applies the permission rules to a decoded region. It returns the grant and
// the region code the master is allowed to see. Hidden regions read as reserved.
// Combinational; assumes the region input comes from mrg_region_decode.
module mrg_access_policy
    import mrg_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] master,
    input  logic       priv,
    input  logic       vis,
    output logic       grant,
    output region_e    shown
);

    logic is_core;
    assign is_core = (master == MST_CORE);

    // Per-region permission and visibility rules.
    always_comb begin
        grant = 1'b0;
        shown = region;
        case (region)
            RGN_DATA_A, RGN_DATA_B, RGN_INSTR: grant = 1'b1;
            RGN_SCRATCH:                       grant = (master != MST_DMA);
            RGN_SYSREG: begin
                if (is_core) grant = priv;
                else if (vis) grant = 1'b1;
                else shown = RGN_RESERVED;
            end
            RGN_COREREG: begin
                if (is_core) grant = priv;
                else shown = RGN_RESERVED;
            end
            default: grant = 1'b0;
        endcase
    end

endmodule

// File: rtl/mem_region_guard.sv
// Module: mem_region_guard (top)
// Classifies each request into an on-chip region and checks it against the
// master and privilege rules. The response is registered one cycle later.
// Assumes one request per strobe; the responses carry no back-pressure.
module mem_region_guard
    import mrg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MASTER_W = 2,
    localparam int RGN_W   = $bits(region_e)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [MASTER_W-1:0] req_master,
    input  logic                req_priv,
    input  logic                cfg_we,
    input  logic                cfg_vis_wdata,
    output logic [RGN_W-1:0]    rsp_region,
    output logic                rsp_grant,
    output logic                rsp_err
);

    region_e dec_region;
    region_e shown_region;
    logic    vis;
    logic    grant_c;

    mrg_region_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (req_addr),
        .region (dec_region)
    );

    mrg_vis_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_vis_wdata),
        .master (req_master),
        .priv   (req_priv),
        .vis    (vis)
    );

    mrg_access_policy u_policy (
        .region (dec_region),
        .master (req_master),
        .priv   (req_priv),
        .vis    (vis),
        .grant  (grant_c),
        .shown  (shown_region)
    );

    // Register the response for one cycle after each strobe; idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_region <= '0;
            rsp_grant  <= 1'b0;
            rsp_err    <= 1'b0;
        end else if (req_valid) begin
            rsp_region <= shown_region;
            rsp_grant  <= grant_c;
            rsp_err    <= !grant_c;
        end else begin
            rsp_region <= '0;
            rsp_grant  <= 1'b0;
            rsp_err    <= 1'b0;
        end
    end

    // R11: grant and error are never raised together.
    p_grant_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_grant && rsp_err));

    // R2: a cycle without a strobe leaves the next response quiet.
    p_quiet_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_grant && !rsp_err));

    // R3: a reserved decode always ends in an error.
    p_reserved_errs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_region == RGN_RESERVED) |=> rsp_err);

    // R4: core registers are never granted to user mode or to non-core masters.
    p_corereg_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_region == RGN_COREREG && !(req_master == MST_CORE && req_priv))
        |=> !rsp_grant);

    // R5: non-core masters see core registers as reserved.
    p_corereg_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_region == RGN_COREREG && req_master != MST_CORE)
        |=> rsp_region == RGN_RESERVED);

    // R9: the DMA master never gets a scratchpad grant.
    p_scratch_no_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_region == RGN_SCRATCH && req_master == MST_DMA) |=> !rsp_grant);

    // R8: the visibility bit moves only after a privileged core write.
    p_vis_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && req_master == MST_CORE && req_priv) |=> $stable(vis));

endmodule

// File: tb/tb_mem_region_guard.sv
// Bench: sweeps every region boundary against every master, privilege mode
// and visibility setting. Expected results are computed from the address map.
module tb_mem_region_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_master;
    logic        req_priv;
    logic        cfg_we;
    logic        cfg_vis_wdata;
    logic [2:0]  rsp_region;
    logic        rsp_grant;
    logic        rsp_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mem_region_guard dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_master(req_master), .req_priv(req_priv), .cfg_we(cfg_we),
        .cfg_vis_wdata(cfg_vis_wdata), .rsp_region(rsp_region),
        .rsp_grant(rsp_grant), .rsp_err(rsp_err)
    );

    // Reference region from the address map (R1).
    function automatic int ref_region(input logic [31:0] a);
        if (a >= 32'hFFE0_0000)                          return 6;
        if (a >= 32'hFFC0_0000)                          return 5;
        if (a >= 32'hFFB0_0000 && a <= 32'hFFB0_0FFF)    return 4;
        if (a >= 32'hFFA0_0000 && a <= 32'hFFA0_3FFF)    return 3;
        if (a >= 32'hFF90_0000 && a <= 32'hFF90_3FFF)    return 2;
        if (a >= 32'hFF80_0000 && a <= 32'hFF80_3FFF)    return 1;
        return 0;
    endfunction

    // Reference grant (R3..R7, R9, R10).
    function automatic bit ref_grant(input int r, input int m, input bit p, input bit v);
        case (r)
            1, 2, 3: return 1;
            4:       return m != 1;
            5:       return (m == 0) ? p : v;
            6:       return (m == 0) && p;
            default: return 0;
        endcase
    endfunction

    // Reference region as reported to the master (R5, R7).
    function automatic int ref_shown(input int r, input int m, input bit v);
        if (r == 6 && m != 0) return 0;
        if (r == 5 && m != 0 && !v) return 0;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One strobe, then sample the registered response away from the edge.
    task automatic do_req(input logic [31:0] a, input int m, input bit p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_master = 2'(m); req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input int m, input bit p, input bit d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_vis_wdata = d; req_master = 2'(m); req_priv = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep_addr(input logic [31:0] a, input bit v);
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                int r;
                bit g;
                r = ref_region(a);
                g = ref_grant(r, m, bit'(p), v);
                do_req(a, m, bit'(p));
                // R1 R4 R5 R6 R7 R9 R10: region and grant for this combination
                check($sformatf("R1/R5/R7 region a=%h m=%0d p=%0d v=%0d", a, m, p, v),
                      int'(rsp_region), ref_shown(r, m, v));
                check($sformatf("R4/R6/R9/R10 grant a=%h m=%0d p=%0d v=%0d", a, m, p, v),
                      int'(rsp_grant), int'(g));
                check($sformatf("R3/R11 err a=%h m=%0d p=%0d", a, m, p),
                      int'(rsp_err), int'(!g));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_master = '0;
        req_priv = 1'b0; cfg_we = 1'b0; cfg_vis_wdata = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 reset region", int'(rsp_region), 0);
        check("R2 reset grant", int'(rsp_grant), 0);
        check("R2 reset err", int'(rsp_err), 0);

        // R8: bit resets hidden; DMA sees system registers as reserved
        do_req(32'hFFC0_0000, 1, 1'b1);
        check("R8 reset vis region", int'(rsp_region), 0);
        check("R8 reset vis err", int'(rsp_err), 1);
        // R11: error lasts one cycle
        @(negedge clk);
        check("R11 err one cycle", int'(rsp_err), 0);
        check("R2 idle grant", int'(rsp_grant), 0);

        // R8: unprivileged write attempts are ignored
        cfg_write(0, 1'b0, 1'b1);
        cfg_write(1, 1'b1, 1'b1);
        cfg_write(2, 1'b1, 1'b1);
        cfg_write(3, 1'b1, 1'b1);
        do_req(32'hFFDF_FFFC, 2, 1'b1);
        check("R8 ignored write region", int'(rsp_region), 0);
        check("R8 ignored write grant", int'(rsp_grant), 0);

        for (int v = 0; v < 2; v++) begin
            cfg_write(0, 1'b1, bit'(v));   // R8: privileged write
            for (int k = 0; k < 6; k++) begin
                logic [31:0] base;
                logic [31:0] size;
                case (k)
                    0: begin base = 32'hFF80_0000; size = 32'h4000;   end
                    1: begin base = 32'hFF90_0000; size = 32'h4000;   end
                    2: begin base = 32'hFFA0_0000; size = 32'h4000;   end
                    3: begin base = 32'hFFB0_0000; size = 32'h1000;   end
                    4: begin base = 32'hFFC0_0000; size = 32'h20_0000; end
                    default: begin base = 32'hFFE0_0000; size = 32'h20_0000; end
                endcase
                sweep_addr(base, bit'(v));
                sweep_addr(base + size - 1, bit'(v));
                sweep_addr(base - 1, bit'(v));
                if (k != 5) sweep_addr(base + size, bit'(v));
            end
            sweep_addr(32'h0000_0000, bit'(v));
            sweep_addr(32'h1234_5678, bit'(v));
        end

        // R8: a privileged write of 0 hides system registers again
        cfg_write(0, 1'b1, 1'b0);
        do_req(32'hFFC0_1000, 3, 1'b0);
        check("R8 hide again region", int'(rsp_region), 0);
        check("R7 hide again grant", int'(rsp_grant), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule